// File: doc/BRIEF.md
# Width-Limited In-Order Commit Controller

This block decides, every cycle, which instructions at the head of the reorder buffer may retire. It looks at a window of the oldest `WIN` entries of the thread chosen by the thread selector. For each entry it sees flags for valid, ready, squashed, executed, non-speculative (which also covers store-conditional and barrier instructions), load, store and fault. It walks the window from the oldest entry and produces one retire strobe per window slot. At most `WIDTH` real instructions are committed per cycle. Squashed entries are dropped without using up that budget.

Some heads must start their work only at the front of a quiet cycle: a non-speculative or barrier instruction, a load that has not executed (treated as uncached), and an executed instruction carrying a fault. Such a head is acted on only when nothing has been committed earlier in the same cycle and the thread has no stores waiting for writeback. The block then raises a matching request carrying the head's sequence number, and the walk stops there.

A registered done sequence number follows the youngest committed instruction. A per-thread committed-store flag lasts for one cycle. It holds back the ROB-empty notification until stores committed by the thread have become visible downstream.

Top module: `commit_unit`

## Requirements
- R1: Retire strobes form a contiguous run starting at slot 0. The walk stops at the first slot whose valid or ready flag is 0.
- R2: At most WIDTH non-squashed entries retire in one cycle. Once WIDTH have committed, no further slot retires, squashed or not.
- R3: A valid, ready, squashed entry retires whatever its other flags say, and it does not count toward WIDTH.
- R4: A non-squashed, unexecuted entry with its non-speculative flag set stops the walk. If no entry has committed earlier in the cycle and storesPending[headTid] is 0, the block raises nonSpecReq and clearCanCommit, with reqSeq set to that entry's sequence number. Otherwise it raises no request.
- R5: A non-squashed, unexecuted entry with load=1 and non-speculative=0 follows the rule of R4 but raises uncachedReq (together with clearCanCommit) instead of nonSpecReq.
- R6: An executed entry with its fault flag set never retires and stops the walk. Under the conditions of R4 it raises trapReq, with reqSeq set to its sequence number.
- R7: A non-squashed, unexecuted entry that is neither non-speculative nor a load raises errUnexec and stops the walk, in any slot.
- R8: After each clock edge, doneSeq holds the sequence number of the youngest entry committed in the previous cycle. It is unchanged when nothing was committed, and it resets to 0.
- R9: robEmptyNotify[t] = robEmpty[t] and not storesPending[t] and not the committed-store flag of thread t. That flag is 1 exactly in the cycle after a store of thread t committed.
- R10: While rstN is low, no retire strobe or request is raised, and doneSeq and all store flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | WIN | Window slot holds an entry |
| headReady | input | WIN | Entry is ready for commit processing |
| headSquashed | input | WIN | Entry was squashed |
| headExecuted | input | WIN | Entry has executed |
| headNonSpec | input | WIN | Non-speculative, store-conditional or barrier |
| headLoad | input | WIN | Entry is a load |
| headStore | input | WIN | Entry is a store |
| headFault | input | WIN | Entry carries a fault |
| headSeq | input | WIN*SEQW | Sequence numbers, slot i at bits [i*SEQW +: SEQW] |
| headTid | input | TIDW | Thread of the window |
| storesPending | input | THREADS | Stores waiting for writeback, per thread |
| robEmpty | input | THREADS | ROB holds no entry of the thread |
| retire | output | WIN | Per-slot retire strobe |
| nonSpecReq | output | 1 | Request to execute a non-speculative head |
| uncachedReq | output | 1 | Request to execute an uncached load |
| trapReq | output | 1 | Fault/trap request |
| clearCanCommit | output | 1 | Clear the head's can-commit bit |
| reqSeq | output | SEQW | Sequence number carried by a request |
| errUnexec | output | 1 | Unexecuted head of unsupported kind |
| doneSeq | output | SEQW | Youngest committed sequence number |
| robEmptyNotify | output | THREADS | ROB-empty notification, per thread |

## Verification
A wrong commit counter or stop flag in the walk shows up in the same cycle, either as a retire pattern longer or shorter than the requirement allows, or as a request raised from a slot after a committed entry. A wrong last-committed index shows up in doneSeq one edge later. A stale or missing store flag shows up in robEmptyNotify in the cycle right after a store commit. The random mix uses many slot orders of squashed, faulting, serializing and store entries, so each of these faults is exposed within a few cycles.

// File: rtl/commit_pkg.sv
package commit_pkg;
  // Strobes from the walk control to the sequence datapath
  typedef struct packed {
    logic anyCommit;
    logic storeCommit;
    logic nsReq;
    logic ucReq;
    logic trapReq;
    logic err;
  } commitStrobes_t;
endpackage

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int WIN   = 4,
  localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CNTW = $clog2(WIDTH + 1)
) (
  input  logic            enable,
  input  logic [WIN-1:0]  headValid,
  input  logic [WIN-1:0]  headReady,
  input  logic [WIN-1:0]  headSquashed,
  input  logic [WIN-1:0]  headExecuted,
  input  logic [WIN-1:0]  headNonSpec,
  input  logic [WIN-1:0]  headLoad,
  input  logic [WIN-1:0]  headStore,
  input  logic [WIN-1:0]  headFault,
  input  logic            storesPend,
  output logic [WIN-1:0]  retire,
  output commitStrobes_t  strobes,
  output logic [IDXW-1:0] lastIdx,
  output logic [IDXW-1:0] reqIdx
);
  logic            stop;
  logic [CNTW-1:0] cnt;

  always_comb begin
    stop    = 1'b0;
    cnt     = '0;
    retire  = '0;
    strobes = '0;
    lastIdx = '0;
    reqIdx  = '0;
    for (int i = 0; i < WIN; i++) begin
      if (!stop) begin
        if (!enable || !headValid[i] || !headReady[i] || cnt == CNTW'(WIDTH)) begin
          stop = 1'b1;
        end else if (headSquashed[i]) begin
          retire[i] = 1'b1;
        end else if (!headExecuted[i]) begin
          stop = 1'b1;
          if (headNonSpec[i] || headLoad[i]) begin
            if (cnt == '0 && !storesPend) begin
              reqIdx = IDXW'(i);
              if (headNonSpec[i]) strobes.nsReq = 1'b1;
              else                strobes.ucReq = 1'b1;
            end
          end else begin
            strobes.err = 1'b1;
          end
        end else if (headFault[i]) begin
          stop = 1'b1;
          if (cnt == '0 && !storesPend) begin
            reqIdx = IDXW'(i);
            strobes.trapReq = 1'b1;
          end
        end else begin
          retire[i] = 1'b1;
          cnt = cnt + 1'b1;
          lastIdx = IDXW'(i);
          strobes.anyCommit = 1'b1;
          if (headStore[i]) strobes.storeCommit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/commit_dp.sv
module commit_dp
  import commit_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int SEQW    = 16,
  parameter int THREADS = 2,
  localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int TIDW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WIN*SEQW-1:0] headSeq,
  input  logic [TIDW-1:0]     headTid,
  input  commitStrobes_t      strobes,
  input  logic [IDXW-1:0]     lastIdx,
  input  logic [IDXW-1:0]     reqIdx,
  input  logic [THREADS-1:0]  storesPending,
  input  logic [THREADS-1:0]  robEmpty,
  output logic [SEQW-1:0]     reqSeq,
  output logic                clearCanCommit,
  output logic [SEQW-1:0]     doneSeq,
  output logic [THREADS-1:0]  robEmptyNotify
);
  logic [THREADS-1:0] storeFlag;

  assign reqSeq         = headSeq[reqIdx*SEQW +: SEQW];
  assign clearCanCommit = strobes.nsReq | strobes.ucReq;

  always_ff @(posedge clk) begin
    if (!rstN)                  doneSeq <= '0;
    else if (strobes.anyCommit) doneSeq <= headSeq[lastIdx*SEQW +: SEQW];
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    always_ff @(posedge clk) begin
      if (!rstN) storeFlag[t] <= 1'b0;
      else       storeFlag[t] <= strobes.storeCommit && (headTid == TIDW'(t));
    end
    assign robEmptyNotify[t] = robEmpty[t] & ~storesPending[t] & ~storeFlag[t];
  end
endmodule

// File: rtl/commit_unit.sv
module commit_unit
  import commit_pkg::*;
#(
  parameter int WIDTH   = 2,
  parameter int WIN     = 4,
  parameter int SEQW    = 16,
  parameter int THREADS = 2,
  localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int TIDW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WIN-1:0]      headValid,
  input  logic [WIN-1:0]      headReady,
  input  logic [WIN-1:0]      headSquashed,
  input  logic [WIN-1:0]      headExecuted,
  input  logic [WIN-1:0]      headNonSpec,
  input  logic [WIN-1:0]      headLoad,
  input  logic [WIN-1:0]      headStore,
  input  logic [WIN-1:0]      headFault,
  input  logic [WIN*SEQW-1:0] headSeq,
  input  logic [TIDW-1:0]     headTid,
  input  logic [THREADS-1:0]  storesPending,
  input  logic [THREADS-1:0]  robEmpty,
  output logic [WIN-1:0]      retire,
  output logic                nonSpecReq,
  output logic                uncachedReq,
  output logic                trapReq,
  output logic                clearCanCommit,
  output logic [SEQW-1:0]     reqSeq,
  output logic                errUnexec,
  output logic [SEQW-1:0]     doneSeq,
  output logic [THREADS-1:0]  robEmptyNotify
);
  commitStrobes_t  strobes;
  logic [IDXW-1:0] lastIdx;
  logic [IDXW-1:0] reqIdx;

  commit_ctrl #(.WIDTH(WIDTH), .WIN(WIN)) i_ctrl (
    .enable(rstN), .headValid(headValid), .headReady(headReady),
    .headSquashed(headSquashed), .headExecuted(headExecuted),
    .headNonSpec(headNonSpec), .headLoad(headLoad), .headStore(headStore),
    .headFault(headFault), .storesPend(storesPending[headTid]),
    .retire(retire), .strobes(strobes), .lastIdx(lastIdx), .reqIdx(reqIdx)
  );

  commit_dp #(.WIN(WIN), .SEQW(SEQW), .THREADS(THREADS)) i_dp (
    .clk(clk), .rstN(rstN), .headSeq(headSeq), .headTid(headTid),
    .strobes(strobes), .lastIdx(lastIdx), .reqIdx(reqIdx),
    .storesPending(storesPending), .robEmpty(robEmpty), .reqSeq(reqSeq),
    .clearCanCommit(clearCanCommit), .doneSeq(doneSeq),
    .robEmptyNotify(robEmptyNotify)
  );

  assign nonSpecReq  = strobes.nsReq;
  assign uncachedReq = strobes.ucReq;
  assign trapReq     = strobes.trapReq;
  assign errUnexec   = strobes.err;
endmodule

// File: rtl/commit_unit_chk.sv
module commit_unit_chk #(
  parameter int WIDTH   = 2,
  parameter int WIN     = 4,
  parameter int SEQW    = 16,
  parameter int THREADS = 2,
  localparam int TIDW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [WIN-1:0]      headSquashed,
  input logic [WIN-1:0]      headExecuted,
  input logic [WIN-1:0]      headFault,
  input logic [TIDW-1:0]     headTid,
  input logic [THREADS-1:0]  storesPending,
  input logic [THREADS-1:0]  robEmpty,
  input logic [WIN-1:0]      retire,
  input logic                nonSpecReq,
  input logic                uncachedReq,
  input logic                trapReq,
  input logic                errUnexec,
  input logic [SEQW-1:0]     doneSeq,
  input logic [THREADS-1:0]  robEmptyNotify
);
  logic [WIN-1:0] realRetire;
  assign realRetire = retire & ~headSquashed;

  for (genvar i = 1; i < WIN; i++) begin : g_prefix
    a_r1_prefix: assert property (@(posedge clk) disable iff (!rstN)
      retire[i] |-> retire[i-1]);
  end

  a_r2_width_limit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(realRetire) <= WIDTH);

  a_r6_no_fault_retire: assert property (@(posedge clk) disable iff (!rstN)
    realRetire == '0 || (realRetire & (~headExecuted | headFault)) == '0);

  a_r4_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nonSpecReq, uncachedReq, trapReq, errUnexec}));

  a_r4_quiet_slot: assert property (@(posedge clk) disable iff (!rstN)
    (nonSpecReq || uncachedReq || trapReq) |->
      (!storesPending[headTid] && realRetire == '0));

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (realRetire == '0) |=> $stable(doneSeq));

  for (genvar t = 0; t < THREADS; t++) begin : g_notify
    a_r9_empty_notify: assert property (@(posedge clk) disable iff (!rstN)
      robEmptyNotify[t] |-> (robEmpty[t] && !storesPending[t]));
  end
endmodule

bind commit_unit commit_unit_chk #(.WIDTH(WIDTH), .WIN(WIN), .SEQW(SEQW),
  .THREADS(THREADS)) i_chk (.*);

// File: tb/test_commit_unit.sv
module test_commit_unit;
  localparam int WIDTH = 2, WIN = 4, SEQW = 16, THREADS = 2, TIDW = 1;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [WIN-1:0] headValid, headReady, headSquashed, headExecuted;
  logic [WIN-1:0] headNonSpec, headLoad, headStore, headFault;
  logic [WIN*SEQW-1:0] headSeq;
  logic [TIDW-1:0] headTid;
  logic [THREADS-1:0] storesPending, robEmpty, robEmptyNotify;
  logic [WIN-1:0] retire;
  logic nonSpecReq, uncachedReq, trapReq, clearCanCommit, errUnexec;
  logic [SEQW-1:0] reqSeq, doneSeq;

  commit_unit #(.WIDTH(WIDTH), .WIN(WIN), .SEQW(SEQW), .THREADS(THREADS)) i_commit_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [SEQW-1:0] mDone = '0;
  logic [THREADS-1:0] mStoreFlag = '0;
  logic [WIN-1:0] eRetire;
  logic eNs, eUc, eTrap, eErr, eAny, eStore;
  logic [SEQW-1:0] eReqSeq, eLastSeq;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SEQW-1:0] seqOf(int i);
    return headSeq[i*SEQW +: SEQW];
  endfunction

  // Expected outputs derived from the requirements
  task automatic predict();
    int cnt = 0;
    bit stop = 0;
    bit quiet;
    eRetire = '0; eNs = 0; eUc = 0; eTrap = 0; eErr = 0; eAny = 0; eStore = 0;
    eReqSeq = '0; eLastSeq = '0;
    for (int i = 0; i < WIN; i++) begin
      if (stop) continue;
      quiet = (cnt == 0) && !storesPending[headTid];
      if (!headValid[i] || !headReady[i] || cnt >= WIDTH) stop = 1;
      else if (headSquashed[i]) eRetire[i] = 1;
      else if (!headExecuted[i]) begin
        stop = 1;
        if (headNonSpec[i]) begin if (quiet) begin eNs = 1; eReqSeq = seqOf(i); end end
        else if (headLoad[i]) begin if (quiet) begin eUc = 1; eReqSeq = seqOf(i); end end
        else eErr = 1;
      end else if (headFault[i]) begin
        stop = 1;
        if (quiet) begin eTrap = 1; eReqSeq = seqOf(i); end
      end else begin
        eRetire[i] = 1; cnt++; eAny = 1; eLastSeq = seqOf(i);
        if (headStore[i]) eStore = 1;
      end
    end
  endtask

  // Settle, compare combinational outputs, then clock and compare registers
  task automatic cycle();
    #2;
    predict();
    check("R1 retire", 64'(retire), 64'(eRetire));
    check("R4 nonSpecReq", 64'(nonSpecReq), 64'(eNs));
    check("R5 uncachedReq", 64'(uncachedReq), 64'(eUc));
    check("R4 clearCanCommit", 64'(clearCanCommit), 64'(eNs | eUc));
    check("R6 trapReq", 64'(trapReq), 64'(eTrap));
    check("R7 errUnexec", 64'(errUnexec), 64'(eErr));
    if (eNs || eUc || eTrap) check("R4 reqSeq", 64'(reqSeq), 64'(eReqSeq));
    check("R9 robEmptyNotify", 64'(robEmptyNotify),
          64'(robEmpty & ~storesPending & ~mStoreFlag));
    @(posedge clk);
    if (eAny) mDone = eLastSeq;
    mStoreFlag = '0;
    if (eStore) mStoreFlag[headTid] = 1'b1;
    #1;
    check("R8 doneSeq", 64'(doneSeq), 64'(mDone));
  endtask

  task automatic setPlain(logic [SEQW-1:0] base);
    headValid = '1; headReady = '1; headSquashed = '0; headExecuted = '1;
    headNonSpec = '0; headLoad = '0; headStore = '0; headFault = '0;
    for (int i = 0; i < WIN; i++) headSeq[i*SEQW +: SEQW] = base + SEQW'(i);
    headTid = '0; storesPending = '0; robEmpty = '0;
  endtask

  task automatic setRandom();
    for (int i = 0; i < WIN; i++) begin
      headValid[i]    = ($urandom % 8) != 0;
      headReady[i]    = ($urandom % 6) != 0;
      headSquashed[i] = ($urandom % 4) == 0;
      headExecuted[i] = ($urandom % 4) != 0;
      headNonSpec[i]  = ($urandom % 6) == 0;
      headLoad[i]     = ($urandom % 3) == 0;
      headStore[i]    = ($urandom % 3) == 0;
      headFault[i]    = ($urandom % 8) == 0;
    end
    headSeq = {$urandom, $urandom};
    headTid = TIDW'($urandom % THREADS);
    storesPending = THREADS'($urandom % 4 == 0 ? $urandom : 0);
    robEmpty = THREADS'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    setPlain(16'h0100);
    // R10: reset state
    repeat (3) @(posedge clk);
    #3;
    check("R10 retire in reset", 64'(retire), 64'(0));
    check("R10 nonSpecReq in reset", 64'(nonSpecReq | trapReq), 64'(0));
    check("R10 doneSeq in reset", 64'(doneSeq), 64'(0));
    @(posedge clk); rstN = 1'b1; #1;

    // R2: width limit with all executed
    setPlain(16'h0200); #2;
    check("R2 width limit", 64'(retire), 64'(4'b0011));
    cycle();
    check("R8 doneSeq after two commits", 64'(doneSeq), 64'(16'h0201));

    // R3: squashed entries do not use the width
    setPlain(16'h0300); headSquashed = 4'b0011; #2;
    check("R3 squashed free", 64'(retire), 64'(4'b1111));
    cycle();

    // R4: non-speculative in slot 0, quiet and with pending stores
    setPlain(16'h0400); headExecuted[0] = 0; headNonSpec[0] = 1; #2;
    check("R4 nonspec slot0", 64'({nonSpecReq, reqSeq}), 64'({1'b1, 16'h0400}));
    cycle();
    setPlain(16'h0410); headExecuted[0] = 0; headNonSpec[0] = 1; storesPending = 2'b01; #2;
    check("R4 stores pending blocks", 64'({nonSpecReq, retire}), 64'(0));
    cycle();
    setPlain(16'h0420); headExecuted[1] = 0; headNonSpec[1] = 1; #2;
    check("R4 not first slot", 64'({nonSpecReq, retire}), 64'({1'b0, 4'b0001}));
    cycle();

    // R5: unexecuted load
    setPlain(16'h0500); headSquashed[0] = 1; headExecuted[1] = 0; headLoad[1] = 1; #2;
    check("R5 uncached after squash", 64'({uncachedReq, reqSeq}), 64'({1'b1, 16'h0501}));
    cycle();

    // R6: fault in slot 0
    setPlain(16'h0600); headFault[0] = 1; #2;
    check("R6 trap slot0", 64'({trapReq, retire}), 64'({1'b1, 4'b0000}));
    cycle();

    // R7: unexecuted other kind
    setPlain(16'h0700); headExecuted[1] = 0; #2;
    check("R7 error flag", 64'({errUnexec, retire}), 64'({1'b1, 4'b0001}));
    cycle();

    // R1: not-ready slot stops walk
    setPlain(16'h0800); headReady[0] = 0; #2;
    check("R1 not ready", 64'(retire), 64'(0));
    cycle();

    // R9: store commit suppresses notify for one cycle
    setPlain(16'h0900); headStore[0] = 1; headTid = 1'b1; cycle();
    setPlain(16'h0910); headValid = '0; headTid = 1'b1; robEmpty = 2'b11; #2;
    check("R9 notify held after store", 64'(robEmptyNotify), 64'(2'b01));
    cycle();
    setPlain(16'h0920); headValid = '0; robEmpty = 2'b11; #2;
    check("R9 notify released", 64'(robEmptyNotify), 64'(2'b11));
    cycle();

    for (int n = 0; n < 800; n++) begin
      setRandom();
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule